// File: doc/BRIEF.md
# Edge-Triggered Input Capture Channel

The block samples an asynchronous input pin and, when a chosen kind of transition arrives, stores the value of a free-running timer count supplied on an input bus. The pin first passes through a two-stage synchronizer and a registered edge detector. Because of this, the stored count is always taken a fixed number of clock cycles after the first clock edge that sees the transition.

Software picks the transition kind: rising, falling, both, or none. An edge prescaler keeps only every Nth qualifying transition, and an interrupt divider raises the request only on every Mth capture. Each capture sets a capture flag. A capture that arrives while that flag is still set also raises an overcapture flag. A single clear input drops both flags.

The timer counter and any compare or PWM logic live outside the block. Disabling the channel blocks captures and returns both internal counters to zero.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset, cap_val_o is 0 and cap_flag_o, ovr_flag_o and irq_o are 0.
- R2: With edge_sel_i = 2'b01, a 0-to-1 pin transition counts as an edge and a 1-to-0 transition does not.
- R3: With edge_sel_i = 2'b10, a 1-to-0 pin transition counts as an edge and a 0-to-1 transition does not.
- R4: With edge_sel_i = 2'b11, both transitions count. With edge_sel_i = 2'b00, no transition counts and cap_val_o does not change.
- R5: Suppose clock edge E is the first rising clock edge that samples a pin transition. The resulting capture loads cap_val_o at clock edge E+3, with the cnt_i value present at that edge. This is the count three cycles later than at E.
- R6: The edge prescaler keeps one counted edge in N, where N = 2**psc_sel_i (1, 2, 4 or 8). Counting starts from the first counted edge after enable, so captures fall on the Nth, 2Nth and later counted edges.
- R7: The interrupt divider keeps one capture in M, where M = irq_div_i + 1 (1 to 4). On the Mth capture, irq_o pulses high for exactly one cycle, in the same cycle that cap_val_o updates.
- R8: Every capture sets cap_flag_o. A cycle with flag_clr_i high clears it. If a capture and a clear fall on the same edge, the flag stays set.
- R9: A capture while cap_flag_o is already 1 sets ovr_flag_o. A cycle with flag_clr_i high clears ovr_flag_o unless a new overcapture happens on the same edge.
- R10: While en_i is low, no capture occurs, cap_val_o holds its value, and both the prescaler and divider counters return to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable |
| edge_sel_i | input | 2 | Edge kind: 00 none, 01 rising, 10 falling, 11 both |
| psc_sel_i | input | 2 | Edge prescaler select, N = 2**psc_sel_i |
| irq_div_i | input | 2 | Interrupt divider, M = irq_div_i + 1 |
| pin_i | input | 1 | Asynchronous input pin |
| cnt_i | input | 16 | Free-running timer count |
| flag_clr_i | input | 1 | Clears capture and overcapture flags |
| cap_val_o | output | 16 | Captured count |
| cap_flag_o | output | 1 | Capture occurred |
| ovr_flag_o | output | 1 | Capture occurred while the flag was still set |
| irq_o | output | 1 | One-cycle interrupt request |

## Verification
The assertions check, on every cycle, that:
- the capture register and capture flag only move while the channel was enabled;
- an overcapture only rises over a flag that was already set;
- every interrupt pulse comes with a set capture flag.

Some behaviour depends on ordering across many cycles, and only the bench scenarios show it:
- the exact three-cycle latency, measured against the count;
- which transitions each edge selection accepts;
- which counted edges the prescaler keeps and which capture the divider picks;
- that both counters restart after a disable;
- that set wins over clear on the same edge.

// File: rtl/ecap_pkg.sv
`timescale 1ns/1ps
package ecap_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam int unsigned CAP_W = 16;
endpackage

// File: rtl/ecap_sync_edge.sv
`timescale 1ns/1ps
module ecap_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[0] <= 1'b0;
        else         sync_q[0] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b0;
        else         sync_q[i] <= sync_q[i-1];
      end
    end
  end

  // registered edge pulses fix the latency at STAGES+1 cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      rise_o <= 1'b0;
      fall_o <= 1'b0;
    end else begin
      prev_q <= sync_q[STAGES-1];
      rise_o <= sync_q[STAGES-1] & ~prev_q;
      fall_o <= ~sync_q[STAGES-1] & prev_q;
    end
  end
endmodule

// File: rtl/ecap_div.sv
`timescale 1ns/1ps
module ecap_div #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic [W-1:0] last_i,
  output logic         hit_o
);
  logic [W-1:0] cnt_q;

  assign hit_o = tick_i && (cnt_q >= last_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!en_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= hit_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/edge_capture_unit.sv
`timescale 1ns/1ps
module edge_capture_unit #(
  parameter int unsigned CAP_W   = ecap_pkg::CAP_W,
  parameter int unsigned SYNC_N  = 2,
  parameter int unsigned PSEL_W  = 2,
  parameter int unsigned DIV_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [1:0]        edge_sel_i,
  input  logic [PSEL_W-1:0] psc_sel_i,
  input  logic [DIV_W-1:0]  irq_div_i,
  input  logic              pin_i,
  input  logic [CAP_W-1:0]  cnt_i,
  input  logic              flag_clr_i,
  output logic [CAP_W-1:0]  cap_val_o,
  output logic              cap_flag_o,
  output logic              ovr_flag_o,
  output logic              irq_o
);
  import ecap_pkg::*;

  localparam int unsigned PSC_W = (1 << PSEL_W) - 1;

  edge_sel_e        sel;
  logic             rise, fall, qual;
  logic             psc_hit, div_hit, cap_evt;
  logic [PSC_W-1:0] psc_last;

  assign sel = edge_sel_e'(edge_sel_i);

  ecap_sync_edge #(.STAGES(SYNC_N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  always_comb begin
    unique case (sel)
      EDGE_RISE: qual = rise;
      EDGE_FALL: qual = fall;
      EDGE_BOTH: qual = rise | fall;
      default:   qual = 1'b0;
    endcase
  end

  assign psc_last = PSC_W'((1 << psc_sel_i) - 1);

  ecap_div #(.W(PSC_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .tick_i (qual),
    .last_i (psc_last),
    .hit_o  (psc_hit)
  );

  assign cap_evt = en_i & psc_hit;

  ecap_div #(.W(DIV_W)) u_irqdiv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .tick_i (cap_evt),
    .last_i (irq_div_i),
    .hit_o  (div_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_val_o  <= '0;
      cap_flag_o <= 1'b0;
      ovr_flag_o <= 1'b0;
      irq_o      <= 1'b0;
    end else begin
      irq_o <= cap_evt & div_hit;
      if (cap_evt) begin
        cap_val_o  <= cnt_i;
        cap_flag_o <= 1'b1;
        if (cap_flag_o)      ovr_flag_o <= 1'b1;
        else if (flag_clr_i) ovr_flag_o <= 1'b0;
      end else if (flag_clr_i) begin
        cap_flag_o <= 1'b0;
        ovr_flag_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ecap_checker.sv
`timescale 1ns/1ps
module ecap_checker #(
  parameter int unsigned CAP_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [CAP_W-1:0] cap_val_o,
  input logic             cap_flag_o,
  input logic             ovr_flag_o,
  input logic             irq_o
);
  p_cap_needs_en_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_val_o != $past(cap_val_o)) |-> $past(en_i));

  p_flag_needs_en_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cap_flag_o) |-> $past(en_i));

  p_ovr_after_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_flag_o) |-> $past(cap_flag_o));

  p_irq_with_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> cap_flag_o);

  p_irq_needs_en_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(en_i));
endmodule

bind edge_capture_unit ecap_checker #(.CAP_W(CAP_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_i       (en_i),
  .cap_val_o  (cap_val_o),
  .cap_flag_o (cap_flag_o),
  .ovr_flag_o (ovr_flag_o),
  .irq_o      (irq_o)
);

// File: tb/edge_capture_unit_tb.sv
`timescale 1ns/1ps
module edge_capture_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  esel = 2'b00;
  logic [1:0]  psel = 2'b00;
  logic [1:0]  idiv = 2'b00;
  logic        pin = 1'b0;
  logic [15:0] tcount = '0;
  logic        clr = 1'b0;
  logic [15:0] cap_val;
  logic        cap_flag, ovr_flag, irq;

  typedef struct packed {
    logic [15:0] val;
    logic        irq;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0, fails = 0, mchecks = 0, mfails = 0;
  int   m_ecnt = 0, m_ccnt = 0;

  always #2 clk = ~clk;
  always_ff @(posedge clk) tcount <= tcount + 16'd1;

  edge_capture_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .edge_sel_i(esel),
    .psc_sel_i(psel), .irq_div_i(idiv), .pin_i(pin), .cnt_i(tcount),
    .flag_clr_i(clr), .cap_val_o(cap_val), .cap_flag_o(cap_flag),
    .ovr_flag_o(ovr_flag), .irq_o(irq)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic configure(input logic [1:0] s, input logic [1:0] p, input logic [1:0] d);
    @(negedge clk);
    en = 1'b0; esel = s; psel = p; idiv = d;
    m_ecnt = 0; m_ccnt = 0;
    @(negedge clk);
    en = 1'b1;
  endtask

  // driver: moves the pin and queues what the requirements predict (R2-R7)
  task automatic drive(input logic v);
    logic q;
    @(negedge clk);
    q = (v != pin) && en && ((esel[0] && v) || (esel[1] && !v));
    pin = v;
    if (q) begin
      m_ecnt++;
      if (m_ecnt == (1 << psel)) begin
        m_ecnt = 0;
        m_ccnt++;
        exp_q.push_back('{val: tcount + 16'd3, irq: (m_ccnt == int'(idiv) + 1)});
        if (m_ccnt == int'(idiv) + 1) m_ccnt = 0;
      end
    end
    repeat (6) @(negedge clk);
  endtask

  task automatic clear_flags;
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  // monitor: every change of cap_val_o must match the head of the queue
  logic [15:0] prev_cap = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (cap_val != prev_cap) begin
        mchecks++;
        if (exp_q.size() == 0) begin
          mfails++;
          $display("FAIL R2/R3/R4: actual capture %0d expected none", cap_val);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (cap_val != e.val || irq != e.irq) begin
            mfails++;
            $display("FAIL R5/R7: actual val %0d irq %0d expected val %0d irq %0d",
                     cap_val, irq, e.val, e.irq);
          end
        end
      end else if (irq) begin
        mchecks++; mfails++;
        $display("FAIL R7: actual irq 1 expected 0");
      end
      prev_cap <= cap_val;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + mchecks + 1, fails + mfails + 1);
    $finish;
  end

  initial begin
    logic [15:0] held;
    repeat (3) @(negedge clk);
    // R1
    check(cap_val == 0 && !cap_flag && !ovr_flag && !irq, "R1", cap_val, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 rising, N=1, M=1
    configure(2'b01, 2'd0, 2'd0);
    drive(1'b1);
    check(cap_flag == 1'b1, "R8", cap_flag, 1);
    check(ovr_flag == 1'b0, "R9", ovr_flag, 0);
    drive(1'b0);
    drive(1'b1);
    check(ovr_flag == 1'b1, "R9", ovr_flag, 1);
    clear_flags();
    check(!cap_flag && !ovr_flag, "R8", cap_flag + ovr_flag, 0);
    drive(1'b0);

    // R3 falling
    configure(2'b10, 2'd0, 2'd0);
    drive(1'b1);
    drive(1'b0);
    drive(1'b1);
    drive(1'b0);

    // R4 both, then none
    configure(2'b11, 2'd0, 2'd0);
    drive(1'b1);
    drive(1'b0);
    configure(2'b00, 2'd0, 2'd0);
    held = cap_val;
    drive(1'b1);
    drive(1'b0);
    check(cap_val == held, "R4", cap_val, held);

    // R6 prescaler N=2 and N=4 on both edges
    configure(2'b11, 2'd1, 2'd0);
    for (int i = 0; i < 4; i++) drive(~pin);
    configure(2'b11, 2'd2, 2'd0);
    for (int i = 0; i < 8; i++) drive(~pin);

    // R7 divider M=3
    configure(2'b11, 2'd0, 2'd2);
    for (int i = 0; i < 7; i++) drive(~pin);

    // R10 disable: no capture, counters restart
    configure(2'b11, 2'd1, 2'd0);
    drive(~pin);
    @(negedge clk); en = 1'b0; m_ecnt = 0; m_ccnt = 0;
    held = cap_val;
    drive(~pin);
    drive(~pin);
    check(cap_val == held, "R10", cap_val, held);
    @(negedge clk); en = 1'b1;
    drive(~pin);
    check(cap_val == held, "R10", cap_val, held);
    drive(~pin);

    // R8 set wins over clear on the same edge
    configure(2'b11, 2'd0, 2'd0);
    clear_flags();
    @(negedge clk);
    exp_q.push_back('{val: tcount + 16'd3, irq: 1'b1});
    pin = ~pin;
    repeat (3) @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    check(cap_flag == 1'b1, "R8", cap_flag, 1);
    check(ovr_flag == 1'b0, "R9", ovr_flag, 0);
    repeat (4) @(negedge clk);

    check(exp_q.size() == 0, "R5", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + mchecks, fails + mfails);
    $finish;
  end
endmodule